// File: doc/BRIEF.md
# Periodic coprocessor wakeup sequencer

This block decides when a small always-on coprocessor is powered and started. It runs on the slow clock and keeps a bank of five period registers, each holding a tick count. A run command from the host does three things: it stores the coprocessor's entry address, enables the timer and starts counting against period 0. When the count reaches the selected period, the block raises a level power enable. In the same cycle it gives a one-cycle start pulse, and the stored entry address is presented alongside.

While the coprocessor is powered the counter stays at zero. A halt or an illegal-instruction report from the core turns power off and starts the count again from zero, so each interval runs from one halt to the next wakeup. The running program can pick which period governs later wakeups. While the system is in deep sleep, that choice is replaced by period 0. Either the host or the coprocessor can clear the timer enable, and after that no further wakeups occur.

Top module: `wake_seq`

## Requirements
- R1: After reset, core_pwr, core_start, timer_en and core_entry are all zero, every period register is zero, and no wakeup happens before a run command.
- R2: A run command presents run_addr on core_entry and sets timer_en. It also resets the period index to 0 and the count to zero. If the core is powered at that moment, power is dropped. These effects show one cycle later.
- R3: The first wakeup after a run command uses period 0. core_start rises exactly P0 clock edges after the edge that sampled run_cmd.
- R4: core_start is high for exactly one cycle, and only in the cycle where core_pwr rises. core_pwr then stays high until a halt, an illegal report or a run command.
- R5: A halt or illegal input sampled while powered clears core_pwr on that edge. The next wakeup comes P clock edges later, where P is the period currently selected.
- R6: A select command with index 0 to 4 chooses the period used for every later wakeup. An index of 5 to 7 leaves the selection unchanged.
- R7: A select command sampled while deep_sleep is high sets the selection to index 0, whatever index it carries.
- R8: A period write with per_idx 0 to 4 loads that register. A write with per_idx 5 to 7 changes no register.
- R9: A period value of zero behaves as one tick.
- R10: A pulse on host_en_clr or core_en_clr clears timer_en on the next edge, and no wakeup follows until the next run command. A core that is already powered keeps running until it halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock; each edge is one tick |
| rst_n | input | 1 | Asynchronous reset, active low |
| per_we | input | 1 | Period register write strobe |
| per_idx | input | 3 | Period register index for the write |
| per_wdata | input | CNT_W | Period value in ticks |
| run_cmd | input | 1 | Host run command |
| run_addr | input | ADDR_W | Entry address stored by the run command |
| sel_cmd | input | 1 | Period-select command from the coprocessor |
| sel_idx | input | 3 | Period index carried by the select command |
| deep_sleep | input | 1 | System is in deep sleep |
| host_en_clr | input | 1 | Host clears the timer enable |
| core_en_clr | input | 1 | Coprocessor clears the timer enable |
| halt | input | 1 | Core has halted |
| illegal | input | 1 | Core hit an illegal instruction |
| core_pwr | output | 1 | Power enable level for the core |
| core_start | output | 1 | One-cycle start pulse |
| core_entry | output | ADDR_W | Entry address for the core |
| timer_en | output | 1 | Current timer enable |

## Verification
Any error in the count, the selected index or the period bank shows at the ports only as a wakeup that comes too early or too late, and only at the next wakeup. The check therefore compares the exact cycle of every start pulse against a schedule predicted from the halt or run edge. An index corrupted by an out-of-range write or select, or one not forced to 0 by deep sleep, becomes visible within one interval as a wrong spacing. A stuck enable shows as a start pulse where none is expected.

// File: rtl/wake_seq.sv
module wake_seq #(
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 11,
  parameter int NUM_PER = 5,
  localparam int IDX_W  = $clog2(NUM_PER)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_we,
  input  logic [IDX_W-1:0]  per_idx,
  input  logic [CNT_W-1:0]  per_wdata,
  input  logic              run_cmd,
  input  logic [ADDR_W-1:0] run_addr,
  input  logic              sel_cmd,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic              deep_sleep,
  input  logic              host_en_clr,
  input  logic              core_en_clr,
  input  logic              halt,
  input  logic              illegal,
  output logic              core_pwr,
  output logic              core_start,
  output logic [ADDR_W-1:0] core_entry,
  output logic              timer_en
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PER - 1);

  logic [CNT_W-1:0] per_q [NUM_PER];
  logic [IDX_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;

  wire [CNT_W-1:0] cur_per = per_q[sel_q];
  wire             en_clr  = host_en_clr | core_en_clr;
  wire             hit     = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, cur_per};
  wire             stop    = halt | illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PER; i++) per_q[i] <= '0;
      sel_q      <= '0;
      cnt_q      <= '0;
      core_pwr   <= 1'b0;
      core_start <= 1'b0;
      core_entry <= '0;
      timer_en   <= 1'b0;
    end else begin
      core_start <= 1'b0;
      if (per_we && per_idx <= LAST) per_q[per_idx] <= per_wdata;
      if (sel_cmd) begin
        if (deep_sleep)          sel_q <= '0;
        else if (sel_idx <= LAST) sel_q <= sel_idx;
      end
      if (run_cmd) begin
        core_entry <= run_addr;
        timer_en   <= 1'b1;
        sel_q      <= '0;
        cnt_q      <= '0;
        core_pwr   <= 1'b0;
      end else begin
        if (en_clr) timer_en <= 1'b0;
        if (core_pwr) begin
          if (stop) core_pwr <= 1'b0;
        end else if (timer_en && !en_clr) begin
          if (hit) begin
            core_pwr   <= 1'b1;
            core_start <= 1'b1;
            cnt_q      <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/wake_seq_chk.sv
module wake_seq_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_cmd,
  input logic [ADDR_W-1:0] run_addr,
  input logic              halt,
  input logic              illegal,
  input logic              host_en_clr,
  input logic              core_en_clr,
  input logic              core_pwr,
  input logic              core_start,
  input logic [ADDR_W-1:0] core_entry,
  input logic              timer_en
);

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  p_start_with_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> core_pwr);

  p_rise_gives_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_pwr) |-> core_start);

  p_pwr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pwr && !halt && !illegal && !run_cmd) |=> core_pwr);

  p_halt_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pwr && (halt || illegal) && !run_cmd) |=> !core_pwr);

  p_run_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_cmd |=> (core_entry == $past(run_addr)) && timer_en && !core_pwr);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_en_clr || core_en_clr) && !run_cmd) |=> !timer_en);

  p_no_wake_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!timer_en && !run_cmd) |=> !core_start);

endmodule

bind wake_seq wake_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .run_addr(run_addr),
  .halt(halt), .illegal(illegal), .host_en_clr(host_en_clr),
  .core_en_clr(core_en_clr), .core_pwr(core_pwr), .core_start(core_start),
  .core_entry(core_entry), .timer_en(timer_en)
);

// File: tb/test_wake_seq.sv
module test_wake_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 11;

  logic clk = 0, rst_n = 0;
  logic per_we = 0, run_cmd = 0, sel_cmd = 0, deep_sleep = 0;
  logic host_en_clr = 0, core_en_clr = 0, halt = 0, illegal = 0;
  logic [2:0] per_idx = 0, sel_idx = 0;
  logic [CNT_W-1:0] per_wdata = 0;
  logic [ADDR_W-1:0] run_addr = 0;
  logic core_pwr, core_start, timer_en;
  logic [ADDR_W-1:0] core_entry;

  wake_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_PER(5)) i_wake_seq (
    .clk(clk), .rst_n(rst_n), .per_we(per_we), .per_idx(per_idx),
    .per_wdata(per_wdata), .run_cmd(run_cmd), .run_addr(run_addr),
    .sel_cmd(sel_cmd), .sel_idx(sel_idx), .deep_sleep(deep_sleep),
    .host_en_clr(host_en_clr), .core_en_clr(core_en_clr), .halt(halt),
    .illegal(illegal), .core_pwr(core_pwr), .core_start(core_start),
    .core_entry(core_entry), .timer_en(timer_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int per_m [5];
  int m_sel = 0;
  bit m_en = 0;
  logic [ADDR_W-1:0] m_ent = 0;
  int exp_cyc_q [$];
  int exp_ent_q [$];
  string exp_req_q [$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff(int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic push_wake(string req);
    if (m_en) begin
      exp_cyc_q.push_back(cyc + 1 + eff(per_m[m_sel]));
      exp_ent_q.push_back(int'(m_ent));
      exp_req_q.push_back(req);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && core_start) begin
      if (exp_cyc_q.size() == 0) begin
        check(0, "R10", "unexpected wake at cycle", cyc, -1);
      end else begin
        int ec, ee;
        string rq;
        ec = exp_cyc_q.pop_front();
        ee = exp_ent_q.pop_front();
        rq = exp_req_q.pop_front();
        check(cyc == ec, rq, "wake cycle", cyc, ec);
        check(int'(core_entry) == ee, rq, "entry at wake", int'(core_entry), ee);
      end
    end
  end

  task automatic write_per(int idx, int val);
    per_we = 1; per_idx = 3'(idx); per_wdata = CNT_W'(val);
    @(negedge clk);
    per_we = 0;
    if (idx < 5) per_m[idx] = val;
  endtask

  task automatic do_run(logic [ADDR_W-1:0] addr, bit expect_wake, string req);
    m_en = 1; m_sel = 0; m_ent = addr;
    if (expect_wake) push_wake(req);
    run_cmd = 1; run_addr = addr;
    @(negedge clk);
    run_cmd = 0;
    check(core_pwr == 0, "R2", "power after run", int'(core_pwr), 0);
    check(core_entry == addr, "R2", "entry after run", int'(core_entry), int'(addr));
    check(timer_en == 1, "R2", "timer_en after run", int'(timer_en), 1);
  endtask

  task automatic wait_wake(string req);
    int n = 0;
    while (!core_pwr && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(core_pwr == 1, req, "core powered", int'(core_pwr), 1);
    @(negedge clk);
    check(core_start == 0 && core_pwr == 1, "R4", "pulse ends, power held",
          int'({core_start, core_pwr}), 1);
    check(exp_cyc_q.size() == 0, req, "pending wakes", exp_cyc_q.size(), 0);
  endtask

  task automatic do_sel(int idx);
    sel_cmd = 1; sel_idx = 3'(idx);
    if (deep_sleep) m_sel = 0;
    else if (idx < 5) m_sel = idx;
    @(negedge clk);
    sel_cmd = 0;
  endtask

  task automatic do_halt(bit ill, string req);
    push_wake(req);
    if (ill) illegal = 1; else halt = 1;
    @(negedge clk);
    halt = 0; illegal = 0;
    check(core_pwr == 0, "R5", "power off after stop", int'(core_pwr), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(core_pwr == 0 && core_start == 0, "R1", "outputs in reset",
          int'({core_pwr, core_start}), 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    check(timer_en == 0 && core_pwr == 0, "R1", "idle after reset",
          int'({timer_en, core_pwr}), 0);
    check(core_entry == 0, "R1", "entry after reset", int'(core_entry), 0);

    write_per(0, 5); write_per(1, 3); write_per(2, 8);
    write_per(3, 0); write_per(4, 2);
    write_per(5, 20);

    do_run(11'h123, 1, "R3");
    wait_wake("R3");
    repeat (3) @(negedge clk);
    check(core_pwr == 1, "R4", "power held while running", int'(core_pwr), 1);

    do_sel(1); do_halt(0, "R6"); wait_wake("R6");
    do_sel(2); do_halt(1, "R5"); wait_wake("R5");
    do_sel(5); do_halt(0, "R6"); wait_wake("R6");
    do_sel(1); do_halt(0, "R8"); wait_wake("R8");
    do_sel(3); do_halt(0, "R9"); wait_wake("R9");
    deep_sleep = 1; do_sel(4); deep_sleep = 0;
    do_halt(0, "R7"); wait_wake("R7");

    do_sel(4);
    do_run(11'h2AA, 1, "R2");
    wait_wake("R2");

    core_en_clr = 1;
    @(negedge clk);
    core_en_clr = 0; m_en = 0;
    check(timer_en == 0, "R10", "core clear", int'(timer_en), 0);
    check(core_pwr == 1, "R10", "core still runs", int'(core_pwr), 1);
    repeat (4) @(negedge clk);
    do_halt(0, "R10");
    repeat (40) @(negedge clk);
    check(core_pwr == 0, "R10", "no wake after core clear", int'(core_pwr), 0);

    do_run(11'h055, 0, "R10");
    repeat (2) @(negedge clk);
    host_en_clr = 1;
    @(negedge clk);
    host_en_clr = 0; m_en = 0;
    check(timer_en == 0, "R10", "host clear", int'(timer_en), 0);
    repeat (30) @(negedge clk);
    check(core_pwr == 0, "R10", "no wake after host clear", int'(core_pwr), 0);
    check(exp_cyc_q.size() == 0, "R3", "wakes left over", exp_cyc_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL R3 watchdog expired: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule